// File: doc/BRIEF.md
# Group-Based Memory VLC Decoder

This block decodes one variable-length codeword per request from a left-aligned bitstream window. Its code tables are not hardwired. Each table is a run of group entries held in a loadable register file. A group covers codewords of equal length and is described by three things: the smallest left-aligned code value in the group, the code length minus one, and a base address into a shared symbol memory. A small table descriptor file records, for each table, where its groups start, how many groups it has, and how the stored symbol word should be interpreted.

For a request, the block compares the window against every group minimum of the selected table and picks the first group, in stored order, whose minimum does not exceed the window. It subtracts that minimum from the window, keeps the top code-length bits of the difference as an offset, and adds the offset to the base address. It then reads the symbol memory and returns the formatted symbol together with the length-minus-one value, which an external shift buffer uses to advance. A window below every minimum raises an error pulse instead of a symbol.

A build parameter selects between two timings. In the base timing the table is read when the request arrives. In the prefetch timing the table is read ahead of the request. All three stores are filled through one write port before decoding starts.

Top module: `vlc_group_decoder`

## Requirements
- R1: The matching group is the first of the table's `cnt` groups, in stored order starting at `start`, whose minimum code is less than or equal to the window. Group slots past `cnt` are never considered.
- R2: The offset is (window − minimum) shifted right by (WIN_W−1−len_m1), truncated to ADDR_W bits. The symbol address is (base + offset) modulo 2^ADDR_W. For example, base 32 with window 0x6402 and minimum 0x6400 at len_m1 14 reads address 33.
- R3: The 2-bit format field of the table descriptor shapes out_sym. Value 0 returns the whole 11-bit word. Value 1 returns word bits [10:4], zero-extended. Value 2 returns word bits [3:0], zero-extended. Value 3 returns word bit 0 only, which serves as the hit/miss flag of a resynchronization library.
- R4: Together with a valid symbol, out_len carries the len_m1 field of the matched group.
- R5: If no group matches, out_err pulses for one cycle, out_valid stays low, and out_sym and out_len keep their previous values.
- R6: In the base timing (PREFETCH=0), a request sampled at a clock edge gives its out_valid or out_err pulse two edges later. In this timing in_tbl is taken together with in_valid. An in_valid raised in the cycle right after an accepted request is ignored.
- R7: In the prefetch timing (PREFETCH=1), pre_load samples in_tbl and loads that table at the edge. A later in_valid uses the loaded table, ignores in_tbl, and gives its result one edge later. Back-to-back requests give back-to-back results. If pre_load and in_valid arrive in the same cycle, the request uses the previously loaded table.
- R8: Memory writes take effect at the clock edge where wr_en is high. wr_sel selects the target. Value 0 is a group entry: min in data[27:12], len_m1 in [11:8], base in [7:0]. Value 1 is a table descriptor: start in data[4:0], cnt in [8:5], format in [10:9]. Value 2 is a symbol word in data[10:0].
- R9: After reset, out_valid and out_err are low and out_sym and out_len are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode request |
| in_tbl | input | TBL_AW (2) | Table index |
| in_win | input | WIN_W (16) | Left-aligned bitstream window |
| pre_load | input | 1 | Table preload strobe (prefetch timing only) |
| wr_en | input | 1 | Memory write enable |
| wr_sel | input | 2 | Write target: 0 group, 1 table, 2 symbol |
| wr_addr | input | WA_W (8) | Write address |
| wr_data | input | DATA_W (28) | Write data |
| out_valid | output | 1 | Symbol valid pulse |
| out_err | output | 1 | No-match pulse |
| out_sym | output | SYM_W (11) | Formatted symbol |
| out_len | output | LEN_W (4) | Code length minus one |

## Verification
Four properties are checked on every cycle. The assertions confirm that an error pulse leaves out_sym and out_len untouched. They also confirm that every result pulse sits the right number of edges after a request, and that no pulse appears without one, in whichever timing is built. Other behaviour needs the bench scenarios. These include choosing the first matching group and skipping slots past the group count, the offset arithmetic and address wrap, the four symbol formats, the dropped request in base timing, and the old-table rule when preload and request coincide. The bench compares both timings against a behavioural model, cycle by cycle.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

    typedef enum logic [1:0] {
        FMT_FULL = 2'd0,
        FMT_HI   = 2'd1,
        FMT_LO   = 2'd2,
        FMT_FLAG = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        WSEL_GRP = 2'd0,
        WSEL_TBL = 2'd1,
        WSEL_SYM = 2'd2,
        WSEL_NONE = 2'd3
    } wsel_e;

endpackage

// File: rtl/vlc_info_store.sv
module vlc_info_store
    import vlc_pkg::*;
#(
    parameter int WIN_W  = 16,
    parameter int ADDR_W = 8,
    parameter int GRP_N  = 32,
    parameter int TBL_N  = 4,
    parameter int MAX_G  = 8,
    localparam int LEN_W  = $clog2(WIN_W),
    localparam int ENT_W  = WIN_W + LEN_W + ADDR_W,
    localparam int GRP_AW = $clog2(GRP_N),
    localparam int TBL_AW = $clog2(TBL_N),
    localparam int CNT_W  = $clog2(MAX_G + 1),
    localparam int TW_W   = 2 + CNT_W + GRP_AW
) (
    input  logic                     clk,
    input  logic                     wr_grp,
    input  logic                     wr_tbl,
    input  logic [GRP_AW-1:0]        wr_gaddr,
    input  logic [TBL_AW-1:0]        wr_taddr,
    input  logic [ENT_W-1:0]         wr_ent,
    input  logic [TW_W-1:0]          wr_tword,
    input  logic [TBL_AW-1:0]        rd_tbl,
    output logic [MAX_G*ENT_W-1:0]   rd_ents,
    output logic [CNT_W-1:0]         rd_cnt,
    output fmt_e                     rd_fmt
);

    logic [ENT_W-1:0]  grp_mem [GRP_N];
    logic [TW_W-1:0]   tbl_mem [TBL_N];
    logic [TW_W-1:0]   tword;
    logic [GRP_AW-1:0] rd_start;

    always_ff @(posedge clk) begin
        if (wr_grp) grp_mem[wr_gaddr] <= wr_ent;
        if (wr_tbl) tbl_mem[wr_taddr] <= wr_tword;
    end

    always_comb begin
        tword    = tbl_mem[rd_tbl];
        rd_start = tword[GRP_AW-1:0];
        rd_cnt   = tword[GRP_AW +: CNT_W];
        rd_fmt   = fmt_e'(tword[GRP_AW+CNT_W +: 2]);
    end

    // One read port per group slot; slots wrap around the group file.
    for (genvar g = 0; g < MAX_G; g++) begin : g_slot
        assign rd_ents[g*ENT_W +: ENT_W] = grp_mem[rd_start + GRP_AW'(g)];
    end

endmodule

// File: rtl/vlc_group_match.sv
module vlc_group_match #(
    parameter int WIN_W  = 16,
    parameter int ADDR_W = 8,
    parameter int MAX_G  = 8,
    localparam int LEN_W = $clog2(WIN_W),
    localparam int ENT_W = WIN_W + LEN_W + ADDR_W,
    localparam int CNT_W = $clog2(MAX_G + 1)
) (
    input  logic [MAX_G*ENT_W-1:0] ents,
    input  logic [CNT_W-1:0]       cnt,
    input  logic [WIN_W-1:0]       win,
    output logic                   hit,
    output logic [ADDR_W-1:0]      addr,
    output logic [LEN_W-1:0]       len_m1
);

    logic [MAX_G-1:0]  ge;
    logic [ENT_W-1:0]  sel;
    logic [WIN_W-1:0]  sel_min;
    logic [ADDR_W-1:0] sel_base;
    logic [WIN_W-1:0]  diff;
    logic [LEN_W-1:0]  shamt;
    logic [ADDR_W-1:0] offs;

    for (genvar g = 0; g < MAX_G; g++) begin : g_cmp
        assign ge[g] = (CNT_W'(g) < cnt) &&
                       (ents[g*ENT_W + ADDR_W + LEN_W +: WIN_W] <= win);
    end

    // Lowest-numbered qualifying slot wins.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int g = MAX_G - 1; g >= 0; g--) begin
            if (ge[g]) begin
                hit = 1'b1;
                sel = ents[g*ENT_W +: ENT_W];
            end
        end
    end

    always_comb begin
        sel_base = sel[ADDR_W-1:0];
        len_m1   = sel[ADDR_W +: LEN_W];
        sel_min  = sel[ADDR_W + LEN_W +: WIN_W];
        diff     = win - sel_min;
        shamt    = LEN_W'(WIN_W - 1) - len_m1;
        offs     = ADDR_W'(diff >> shamt);
        addr     = sel_base + offs;
    end

endmodule

// File: rtl/vlc_sym_store.sv
module vlc_sym_store
    import vlc_pkg::*;
#(
    parameter int SYM_W  = 11,
    parameter int ADDR_W = 8,
    parameter int HI_W   = 7,
    parameter int LO_W   = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SYM_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  fmt_e              rd_fmt,
    output logic [SYM_W-1:0]  rd_sym
);

    logic [SYM_W-1:0] mem [DEPTH];
    logic [SYM_W-1:0] word;
    logic [SYM_W-1:0] sym_d, sym_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_comb begin
        word  = mem[rd_addr];
        sym_d = sym_q;
        if (rd_en) begin
            unique case (rd_fmt)
                FMT_FULL: sym_d = word;
                FMT_HI:   sym_d = SYM_W'(word[SYM_W-1 -: HI_W]);
                FMT_LO:   sym_d = SYM_W'(word[LO_W-1:0]);
                FMT_FLAG: sym_d = SYM_W'(word[0]);
                default:  sym_d = word;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sym_q <= '0;
        else        sym_q <= sym_d;
    end

    assign rd_sym = sym_q;

endmodule

// File: rtl/vlc_group_decoder.sv
module vlc_group_decoder
    import vlc_pkg::*;
#(
    parameter int WIN_W    = 16,
    parameter int SYM_W    = 11,
    parameter int ADDR_W   = 8,
    parameter int GRP_N    = 32,
    parameter int TBL_N    = 4,
    parameter int MAX_G    = 8,
    parameter int HI_W     = 7,
    parameter int LO_W     = 4,
    parameter int PREFETCH = 0,
    localparam int LEN_W   = $clog2(WIN_W),
    localparam int ENT_W   = WIN_W + LEN_W + ADDR_W,
    localparam int GRP_AW  = $clog2(GRP_N),
    localparam int TBL_AW  = $clog2(TBL_N),
    localparam int CNT_W   = $clog2(MAX_G + 1),
    localparam int TW_W    = 2 + CNT_W + GRP_AW,
    localparam int DW0     = (ENT_W > SYM_W) ? ENT_W : SYM_W,
    localparam int DATA_W  = (DW0 > TW_W) ? DW0 : TW_W,
    localparam int WA0     = (ADDR_W > GRP_AW) ? ADDR_W : GRP_AW,
    localparam int WA_W    = (WA0 > TBL_AW) ? WA0 : TBL_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [TBL_AW-1:0] in_tbl,
    input  logic [WIN_W-1:0]  in_win,
    input  logic              pre_load,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WA_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              out_valid,
    output logic              out_err,
    output logic [SYM_W-1:0]  out_sym,
    output logic [LEN_W-1:0]  out_len
);

    localparam bit PF = (PREFETCH != 0);

    typedef struct packed {
        logic                   pend;
        logic [WIN_W-1:0]       win;
        logic [MAX_G*ENT_W-1:0] ents;
        logic [CNT_W-1:0]       cnt;
        fmt_e                   fmt;
        logic                   ov;
        logic                   oe;
        logic [LEN_W-1:0]       olen;
    } state_t;

    state_t st_d, st_q;

    logic [MAX_G*ENT_W-1:0] rd_ents;
    logic [CNT_W-1:0]       rd_cnt;
    fmt_e                   rd_fmt;
    logic                   accept, load, go;
    logic [WIN_W-1:0]       cur_win;
    logic                   m_hit;
    logic [ADDR_W-1:0]      m_addr;
    logic [LEN_W-1:0]       m_len;
    logic                   w_grp, w_tbl, w_sym;

    always_comb begin
        w_grp = wr_en && (wsel_e'(wr_sel) == WSEL_GRP);
        w_tbl = wr_en && (wsel_e'(wr_sel) == WSEL_TBL);
        w_sym = wr_en && (wsel_e'(wr_sel) == WSEL_SYM);
    end

    vlc_info_store #(
        .WIN_W (WIN_W),
        .ADDR_W(ADDR_W),
        .GRP_N (GRP_N),
        .TBL_N (TBL_N),
        .MAX_G (MAX_G)
    ) i_info (
        .clk     (clk),
        .wr_grp  (w_grp),
        .wr_tbl  (w_tbl),
        .wr_gaddr(wr_addr[GRP_AW-1:0]),
        .wr_taddr(wr_addr[TBL_AW-1:0]),
        .wr_ent  (wr_data[ENT_W-1:0]),
        .wr_tword(wr_data[TW_W-1:0]),
        .rd_tbl  (in_tbl),
        .rd_ents (rd_ents),
        .rd_cnt  (rd_cnt),
        .rd_fmt  (rd_fmt)
    );

    vlc_group_match #(
        .WIN_W (WIN_W),
        .ADDR_W(ADDR_W),
        .MAX_G (MAX_G)
    ) i_match (
        .ents  (st_q.ents),
        .cnt   (st_q.cnt),
        .win   (cur_win),
        .hit   (m_hit),
        .addr  (m_addr),
        .len_m1(m_len)
    );

    vlc_sym_store #(
        .SYM_W (SYM_W),
        .ADDR_W(ADDR_W),
        .HI_W  (HI_W),
        .LO_W  (LO_W)
    ) i_sym (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (w_sym),
        .wr_addr(wr_addr[ADDR_W-1:0]),
        .wr_data(wr_data[SYM_W-1:0]),
        .rd_en  (go && m_hit),
        .rd_addr(m_addr),
        .rd_fmt (st_q.fmt),
        .rd_sym (out_sym)
    );

    always_comb begin
        st_d    = st_q;
        accept  = PF ? 1'b0 : (in_valid && !st_q.pend);
        load    = PF ? pre_load : accept;
        go      = PF ? in_valid : st_q.pend;
        cur_win = PF ? in_win : st_q.win;

        if (load) begin
            st_d.ents = rd_ents;
            st_d.cnt  = rd_cnt;
            st_d.fmt  = rd_fmt;
        end
        st_d.pend = accept;
        if (accept) st_d.win = in_win;

        st_d.ov = go && m_hit;
        st_d.oe = go && !m_hit;
        if (go && m_hit) st_d.olen = m_len;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_err   = st_q.oe;
    assign out_len   = st_q.olen;

    AST_ERR_KEEPS_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> $stable(out_sym)); // R5
    AST_ERR_KEEPS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> $stable(out_len)); // R5

    if (PF) begin : g_pf_chk
        AST_PF_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_valid || out_err)); // R7
        AST_PF_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid || out_err) |-> $past(in_valid)); // R7
    end else begin : g_base_chk
        AST_BASE_RESULT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !st_q.pend) |-> ##2 (out_valid || out_err)); // R6
        AST_BASE_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid || out_err) |-> $past(in_valid, 2)); // R6
    end

endmodule

// File: tb/test_vlc_group_decoder.sv
module test_vlc_group_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_addr = '0;
    logic [27:0] wr_data = '0;

    logic        b_iv = 1'b0, b_pl = 1'b0;
    logic [1:0]  b_tbl = '0;
    logic [15:0] b_win = '0;
    logic        b_ov, b_oe;
    logic [10:0] b_sym;
    logic [3:0]  b_len;

    logic        p_iv = 1'b0, p_pl = 1'b0;
    logic [1:0]  p_tbl = '0;
    logic [15:0] p_win = '0;
    logic        p_ov, p_oe;
    logic [10:0] p_sym;
    logic [3:0]  p_len;

    always #2 clk = ~clk;

    vlc_group_decoder #(.PREFETCH(0)) i_vlc_group_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .in_tbl(b_tbl), .in_win(b_win),
        .pre_load(b_pl), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_valid(b_ov), .out_err(b_oe), .out_sym(b_sym),
        .out_len(b_len));

    vlc_group_decoder #(.PREFETCH(1)) i_vlc_group_decoder_pf (
        .clk(clk), .rst_n(rst_n), .in_valid(p_iv), .in_tbl(p_tbl), .in_win(p_win),
        .pre_load(p_pl), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_valid(p_ov), .out_err(p_oe), .out_sym(p_sym),
        .out_len(p_len));

    int total = 0, bad = 0, cyc = 0;
    bit finished = 1'b0;

    int m_min [32], m_len [32], m_base [32];
    int m_start [4], m_cnt [4], m_fmt [4];
    int m_sym [256];

    // Expected result: {cycle[47:16], err[15], len[14:11], sym[10:0]}
    logic [47:0] qb [$], qp [$];
    string       qb_r [$], qp_r [$];
    int b_last_sym = 0, b_last_len = 0, p_last_sym = 0, p_last_len = 0;
    int pf_tbl = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic ref_dec(input int tbl, input int win, output bit err,
                           output int len, output int sym);
        err = 1'b1; len = 0; sym = 0;
        for (int g = 0; g < m_cnt[tbl]; g++) begin
            int i, sh, off, a, w;
            i = (m_start[tbl] + g) % 32;
            if (m_min[i] <= win) begin
                sh  = 15 - m_len[i];
                off = ((win - m_min[i]) >> sh) & 255;
                a   = (m_base[i] + off) & 255;
                w   = m_sym[a];
                err = 1'b0;
                len = m_len[i];
                case (m_fmt[tbl])
                    0: sym = w;
                    1: sym = (w >> 4) & 127;
                    2: sym = w & 15;
                    default: sym = w & 1;
                endcase
                break;
            end
        end
    endtask

    task automatic check_port(input logic [47:0] e, input string req, input logic ov,
                              input logic oe, input logic [10:0] sym, input logic [3:0] len);
        if (e[15]) begin
            chk(oe === 1'b1 && ov === 1'b0, req, "err pulse", {ov, oe}, 1);
        end else begin
            chk(ov === 1'b1 && oe === 1'b0, req, "valid pulse", {ov, oe}, 2);
        end
        chk(sym === e[10:0], req, "out_sym", int'(sym), int'(e[10:0]));
        chk(len === e[14:11], req, "out_len", int'(len), int'(e[14:11]));
    endtask

    logic [47:0] eb, ep;
    always @(negedge clk) begin
        if (rst_n) begin
            if (qb.size() > 0 && qb[0][47:16] == cyc[31:0]) begin
                eb = qb.pop_front();
                check_port(eb, qb_r.pop_front(), b_ov, b_oe, b_sym, b_len);
            end else begin
                chk(!b_ov && !b_oe, "R6", "idle base output", {b_ov, b_oe}, 0);
            end
            if (qp.size() > 0 && qp[0][47:16] == cyc[31:0]) begin
                ep = qp.pop_front();
                check_port(ep, qp_r.pop_front(), p_ov, p_oe, p_sym, p_len);
            end else begin
                chk(!p_ov && !p_oe, "R7", "idle prefetch output", {p_ov, p_oe}, 0);
            end
        end
    end

    task automatic wr(input int sel, input int addr, input logic [27:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_addr = 8'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wgrp(input int i, input int mn, input int ln, input int bs);
        m_min[i] = mn; m_len[i] = ln; m_base[i] = bs;
        wr(0, i, {16'(mn), 4'(ln), 8'(bs)});
    endtask

    task automatic wtbl(input int t, input int st, input int cn, input int fm);
        m_start[t] = st; m_cnt[t] = cn; m_fmt[t] = fm;
        wr(1, t, 28'({2'(fm), 4'(cn), 5'(st)}));
    endtask

    task automatic wsym(input int a, input int v);
        m_sym[a] = v & 2047;
        wr(2, a, 28'(v & 2047));
    endtask

    function automatic logic [47:0] mk(input int c, input bit err, input int len, input int sym);
        return {32'(c), err, 4'(len), 11'(sym)};
    endfunction

    task automatic push_b(input int c, input int tbl, input int win, input string req);
        bit e; int l, s;
        ref_dec(tbl, win, e, l, s);
        if (e) begin l = b_last_len; s = b_last_sym; end
        else begin b_last_len = l; b_last_sym = s; end
        qb.push_back(mk(c, e, l, s)); qb_r.push_back(req);
    endtask

    task automatic push_p(input int c, input int tbl, input int win, input string req);
        bit e; int l, s;
        ref_dec(tbl, win, e, l, s);
        if (e) begin l = p_last_len; s = p_last_sym; end
        else begin p_last_len = l; p_last_sym = s; end
        qp.push_back(mk(c, e, l, s)); qp_r.push_back(req);
    endtask

    task automatic dec_b(input int tbl, input int win, input string req);
        @(negedge clk);
        b_iv = 1'b1; b_tbl = 2'(tbl); b_win = 16'(win);
        push_b(cyc + 2, tbl, win, req);
        @(negedge clk);
        b_iv = 1'b0;
        @(negedge clk);
    endtask

    task automatic pf_load(input int tbl);
        @(negedge clk);
        p_pl = 1'b1; p_tbl = 2'(tbl);
        @(negedge clk);
        p_pl = 1'b0;
        pf_tbl = tbl;
    endtask

    task automatic dec_p(input int win, input string req);
        @(negedge clk);
        p_iv = 1'b1; p_win = 16'(win); p_tbl = 2'(pf_tbl + 1);
        push_p(cyc + 1, pf_tbl, win, req);
        @(negedge clk);
        p_iv = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(b_sym == 0 && b_len == 0, "R9", "base reset outputs", {b_sym, b_len}, 0);
        chk(p_sym == 0 && p_len == 0, "R9", "prefetch reset outputs", {p_sym, p_len}, 0);

        // R8: fill all stores through the write port
        for (int a = 0; a < 256; a++) wsym(a, a * 37 + 5);
        wgrp(0, 'h8000, 1, 0);
        wgrp(1, 'h4000, 2, 2);
        wgrp(2, 'h1000, 3, 4);
        wgrp(3, 'h0000, 0, 255);   // beyond table 0's count: must be skipped
        wgrp(4, 'h6400, 14, 32);
        wgrp(5, 'h0100, 7, 40);
        wgrp(8, 'h0000, 3, 64);
        wgrp(12, 'hF000, 3, 100);
        wgrp(13, 'h0000, 15, 200);
        wtbl(0, 0, 3, 0);
        wtbl(1, 4, 2, 1);
        wtbl(2, 8, 1, 2);
        wtbl(3, 12, 2, 3);

        // R1 R2 R4: table 0, full word, three groups
        dec_b(0, 'h8000, "R1");
        dec_b(0, 'hFFFF, "R2");
        dec_b(0, 'h4000, "R1");
        dec_b(0, 'h7FFF, "R4");
        dec_b(0, 'h3FFF, "R2");
        // R5: below every counted group (slot 3 is outside cnt) -> error, hold
        dec_b(0, 'h0FFF, "R5");
        dec_b(0, 'h1000, "R1");
        // R2 R3: table 1 upper field, base 32 + offset 1 = address 33
        dec_b(1, 'h6402, "R2");
        dec_b(1, 'h0123, "R3");
        dec_b(1, 'h00FF, "R5");
        // R3: lower nibble and flag formats, R2 address wrap
        dec_b(2, 'hA5A5, "R3");
        dec_b(2, 'h0000, "R3");
        dec_b(3, 'hF123, "R3");
        dec_b(3, 'h00C0, "R2");
        // R8: symbol rewrite is visible on the next decode
        wsym(33, 'h7F0);
        dec_b(1, 'h6402, "R8");

        // R6: request in the cycle after an accepted one is dropped
        @(negedge clk);
        b_iv = 1'b1; b_tbl = 2'd0; b_win = 16'h8000;
        push_b(cyc + 2, 0, 'h8000, "R6");
        @(negedge clk);
        b_tbl = 2'd1; b_win = 16'h6402;
        @(negedge clk);
        b_iv = 1'b0;
        repeat (3) @(negedge clk);
        dec_b(2, 'h1234, "R6");

        // R7: prefetch timing
        pf_load(1);
        dec_p('h6402, "R7");
        dec_p('h00FF, "R5");
        pf_load(3);
        // back-to-back requests
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            p_iv = 1'b1; p_win = 16'('hF000 + k * 'h0111); p_tbl = 2'd0;
            push_p(cyc + 1, pf_tbl, 'hF000 + k * 'h0111, "R7");
            @(negedge clk);
        end
        p_iv = 1'b0;
        // preload and request together: request uses the old table (3)
        @(negedge clk);
        p_iv = 1'b1; p_pl = 1'b1; p_tbl = 2'd0; p_win = 16'h0050;
        push_p(cyc + 1, pf_tbl, 'h0050, "R7");
        @(negedge clk);
        p_iv = 1'b0; p_pl = 1'b0;
        pf_tbl = 0;
        dec_p('h0050, "R7");
        dec_p('hC000, "R1");

        repeat (4) @(negedge clk);
        chk(qb.size() == 0, "R6", "base results outstanding", qb.size(), 0);
        chk(qp.size() == 0, "R7", "prefetch results outstanding", qp.size(), 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule